// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures the frequency of a slow clock against a fast reference clock. It counts how many reference cycles occur while a programmed number of slow clock periods elapse. The slow clock is picked from three independent sources. Each source is brought into the reference domain by its own synchroniser, and each synchroniser produces a single-cycle pulse on every rising slow edge. Because of this, changing the selection never sends a glitching clock into the counter.

Firmware writes a configuration word through a single write strobe. The word holds the source select, the window length in slow cycles, a start bit and a cycling bit. A one-shot measurement begins when the stored start bit goes from 0 to 1. When the measurement completes, the ready flag rises and the count appears on the result port. In cycling mode, measurements run back to back and the result is refreshed at the end of every window. Cycling mode is the state the block is in after reset. A window of zero slow cycles turns a measurement into a wait for the next slow edge. The count saturates instead of wrapping, and an overflow flag is raised when it saturates.

Top module: `slow_clk_meter`

## Requirements
- R1: After reset, `cal_ready`, `cal_result` and `cal_overflow` are 0, source 0 is selected, the window is `RST_WIN`, the start bit is 0 and cycling is enabled, so a measurement begins without any write.
- R2: A completed window of N slow periods on a source whose period is P reference cycles reports N*P. Select codes 0, 1 and 2 pick `slow_src[0]`, `slow_src[1]` and `slow_src[2]`, and any other code falls back to `slow_src[0]`.
- R3: A one-shot measurement starts only when the stored start bit changes from 0 to 1. Writing 1 again while the bit is already 1 neither restarts the measurement nor touches the ready flag or the result.
- R4: After a write that raises the start bit, `cal_ready` is 0 by the second rising clock edge. It stays 0 until the new measurement completes, and then it goes to 1.
- R5: With a window of 0, the ready flag rises at the first slow edge seen after the start, and the result is 0.
- R6: With cycling enabled, each window begins at the closing edge of the previous one and the result is refreshed after every window. A newly written window length takes effect from the next window.
- R7: A count that would exceed the all-ones value of `CNT_W` bits is reported as all ones with `cal_overflow` = 1. The next measurement that does not saturate clears the flag.
- R8: Writing start = 0 and cycle = 0 returns the block to idle. Any measurement in progress is dropped, and the result and ready flag keep their values.
- R9: Every rising edge of the selected slow clock gives exactly one single-cycle pulse in the reference domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_src | input | NUM_SRC | Slow clock sources, asynchronous to `clk` |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_sel | input | SEL_W | Source select code |
| cfg_window | input | WIN_W | Window length in slow cycles |
| cfg_start | input | 1 | One-shot start bit (rising edge starts) |
| cfg_cycle | input | 1 | Continuous measurement enable |
| cal_ready | output | 1 | Measurement complete flag |
| cal_result | output | CNT_W | Reference cycles counted in the last window |
| cal_overflow | output | 1 | Last result saturated |

## Verification
The embedded assertions check the following on every cycle:
- each synchroniser pulse lasts exactly one cycle and each start detection is a single pulse (R9, R3);
- the ready flag drops right after a start edge (R4);
- the ready flag rises only on a slow edge;
- an overflow always comes with an all-ones result (R7);
- a zero window completes with a zero result (R5);
- the result never moves while the block is idle (R8).

The exact counts need the bench's directed scenarios, because they depend on the slow periods that the bench drives. These scenarios cover the count for each source and for the fallback select code, the refresh in cycling mode after the window length or the period changes, the saturation value, abort to idle, and the fact that writing the start bit again at the same level has no effect.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;

   typedef enum logic [1:0] {
      CAL_IDLE  = 2'd0,
      CAL_ARM   = 2'd1,
      CAL_COUNT = 2'd2
   } cal_state_e;

   typedef struct packed {
      logic start;
      logic cycle;
   } cal_mode_t;

endpackage

// File: rtl/slow_edge_sync.sv
module slow_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_in,
   output logic rise_pulse
);

   localparam int PIPE_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("slow_edge_sync: STAGES must be at least 2");
   end

   logic [PIPE_W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
      end else begin
         pipe_q <= {pipe_q[PIPE_W-2:0], slow_in};
      end
   end

   assign rise_pulse = pipe_q[STAGES-1] & ~pipe_q[STAGES];

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs
   import slow_cal_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int WIN_W   = 15,
   parameter int RST_WIN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [WIN_W-1:0] win_in,
   input  logic             start_in,
   input  logic             cycle_in,
   output logic [SEL_W-1:0] sel_q,
   output logic [WIN_W-1:0] win_q,
   output cal_mode_t        mode_q,
   output logic             start_rise
);

   localparam int WIN_MAX = (1 << WIN_W) - 2;

   if (RST_WIN > WIN_MAX || RST_WIN < 0) begin : g_bad_rst_win
      $error("cal_cfg_regs: RST_WIN outside the legal window range");
   end

   logic start_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q        <= '0;
         win_q        <= WIN_W'(RST_WIN);
         mode_q.start <= 1'b0;
         mode_q.cycle <= 1'b1;
         start_prev_q <= 1'b0;
      end else begin
         start_prev_q <= mode_q.start;
         if (wr) begin
            sel_q        <= sel_in;
            win_q        <= win_in;
            mode_q.start <= start_in;
            mode_q.cycle <= cycle_in;
         end
      end
   end

   assign start_rise = mode_q.start & ~start_prev_q;

   // R3
   start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise |=> !start_rise);

endmodule

// File: rtl/cal_counter.sv
module cal_counter
   import slow_cal_pkg::*;
#(
   parameter int WIN_W = 15,
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_edge,
   input  logic [WIN_W-1:0] win,
   input  logic             cycle_en,
   input  logic             start_lvl,
   input  logic             start_rise,
   output logic             ready,
   output logic [CNT_W-1:0] result,
   output logic             overflow
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("cal_counter: CNT_W must be at least 4");
   end

   cal_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [WIN_W-1:0] left_q;
   logic             ovf_run_q;
   logic             cnt_full;
   logic             run_on;
   logic             last_edge;
   logic             win_zero;

   assign cnt_full  = &cnt_q;
   assign run_on    = cycle_en | start_lvl;
   assign last_edge = slow_edge && (left_q == WIN_W'(1));
   assign win_zero  = (win == '0);

   always_comb begin
      if (cnt_full) cnt_inc = cnt_q;
      else          cnt_inc = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CAL_IDLE;
         cnt_q     <= '0;
         left_q    <= '0;
         ovf_run_q <= 1'b0;
         ready     <= 1'b0;
         result    <= '0;
         overflow  <= 1'b0;
      end else if (start_rise) begin
         state_q <= CAL_ARM;
         ready   <= 1'b0;
      end else begin
         unique case (state_q)
            CAL_IDLE: begin
               if (cycle_en) state_q <= CAL_ARM;
            end
            CAL_ARM: begin
               if (!run_on) begin
                  state_q <= CAL_IDLE;
               end else if (slow_edge) begin
                  if (win_zero) begin
                     ready    <= 1'b1;
                     result   <= '0;
                     overflow <= 1'b0;
                     state_q  <= cycle_en ? CAL_ARM : CAL_IDLE;
                  end else begin
                     state_q   <= CAL_COUNT;
                     cnt_q     <= '0;
                     ovf_run_q <= 1'b0;
                     left_q    <= win;
                  end
               end
            end
            CAL_COUNT: begin
               if (!run_on) begin
                  state_q <= CAL_IDLE;
               end else if (last_edge) begin
                  result    <= cnt_inc;
                  overflow  <= ovf_run_q | cnt_full;
                  ready     <= 1'b1;
                  cnt_q     <= '0;
                  ovf_run_q <= 1'b0;
                  left_q    <= win;
                  if (!cycle_en)     state_q <= CAL_IDLE;
                  else if (win_zero) state_q <= CAL_ARM;
               end else begin
                  cnt_q     <= cnt_inc;
                  ovf_run_q <= ovf_run_q | cnt_full;
                  if (slow_edge) left_q <= left_q - WIN_W'(1);
               end
            end
            default: state_q <= CAL_IDLE;
         endcase
      end
   end

   // R4
   ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise |=> !ready);

   // R6
   ready_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(slow_edge));

   // R7
   ovf_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (&result));

   // R5
   zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && $past(state_q) == CAL_ARM) |-> (result == '0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == CAL_IDLE && state_q == CAL_IDLE) |-> $stable(result));

endmodule

// File: rtl/slow_clk_meter.sv
module slow_clk_meter
   import slow_cal_pkg::*;
#(
   parameter int NUM_SRC     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int WIN_W       = 15,
   parameter int CNT_W       = 24,
   parameter int RST_WIN     = 1,
   parameter int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] slow_src,
   input  logic               cfg_wr,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [WIN_W-1:0]   cfg_window,
   input  logic               cfg_start,
   input  logic               cfg_cycle,
   output logic               cal_ready,
   output logic [CNT_W-1:0]   cal_result,
   output logic               cal_overflow
);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("slow_clk_meter: NUM_SRC must be at least 1");
   end
   if ((1 << SEL_W) < NUM_SRC) begin : g_bad_sel
      $error("slow_clk_meter: SEL_W too narrow for NUM_SRC");
   end

   logic [SEL_W-1:0]   sel_q;
   logic [WIN_W-1:0]   win_q;
   cal_mode_t          mode_q;
   logic               start_rise;
   logic [NUM_SRC-1:0] src_edges;
   logic               edge_sel;

   cal_cfg_regs #(
      .SEL_W   (SEL_W),
      .WIN_W   (WIN_W),
      .RST_WIN (RST_WIN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cfg_wr),
      .sel_in     (cfg_sel),
      .win_in     (cfg_window),
      .start_in   (cfg_start),
      .cycle_in   (cfg_cycle),
      .sel_q      (sel_q),
      .win_q      (win_q),
      .mode_q     (mode_q),
      .start_rise (start_rise)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
      slow_edge_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk        (clk),
         .rst_n      (rst_n),
         .slow_in    (slow_src[g]),
         .rise_pulse (src_edges[g])
      );
   end

   always_comb begin
      edge_sel = src_edges[0];
      for (int i = 1; i < NUM_SRC; i++) begin
         if (sel_q == SEL_W'(i)) edge_sel = src_edges[i];
      end
   end

   cal_counter #(
      .WIN_W (WIN_W),
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_edge  (edge_sel),
      .win        (win_q),
      .cycle_en   (mode_q.cycle),
      .start_lvl  (mode_q.start),
      .start_rise (start_rise),
      .ready      (cal_ready),
      .result     (cal_result),
      .overflow   (cal_overflow)
   );

   // R9
   sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel |=> !edge_sel || (sel_q != $past(sel_q)));

endmodule

// File: tb/sim_slow_clk_meter.sv
`timescale 1ns/1ps
module sim_slow_clk_meter;

   localparam int CNT_W = 10;
   localparam int WIN_W = 15;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       slow = '0;
   logic             cfg_wr = 1'b0;
   logic [1:0]       cfg_sel = '0;
   logic [WIN_W-1:0] cfg_window = '0;
   logic             cfg_start = 1'b0;
   logic             cfg_cycle = 1'b0;
   logic             cal_ready;
   logic [CNT_W-1:0] cal_result;
   logic             cal_overflow;

   int per [3];
   int ph  [3];
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   slow_clk_meter #(
      .NUM_SRC(3), .SYNC_STAGES(2), .WIN_W(WIN_W), .CNT_W(CNT_W), .RST_WIN(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .slow_src(slow), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_window(cfg_window), .cfg_start(cfg_start),
      .cfg_cycle(cfg_cycle), .cal_ready(cal_ready), .cal_result(cal_result),
      .cal_overflow(cal_overflow)
   );

   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) begin
         if (ph[i] + 1 >= per[i]) ph[i] = 0;
         else ph[i] = ph[i] + 1;
         slow[i] = (ph[i] < per[i] / 2);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input int sel, input int win, input bit st, input bit cy);
      @(negedge clk);
      cfg_sel = 2'(sel); cfg_window = WIN_W'(win); cfg_start = st; cfg_cycle = cy;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_ready(input int max, output int n);
      n = 0;
      while (!cal_ready && n < max) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic oneshot(input int sel, input int win, input string req, input int exp);
      int n;
      write_cfg(sel, win, 1'b0, 1'b0);
      write_cfg(sel, win, 1'b1, 1'b0);
      @(negedge clk);
      check("R4 ready dropped after start", int'(cal_ready), 0);
      wait_ready(4000, n);
      check("R4 ready rose after window", int'(cal_ready), 1);
      check("R4 ready low for whole window", int'(n >= exp), 1);
      check(req, int'(cal_result), exp);
   endtask

   task automatic t_reset();
      check("R1 ready after reset", int'(cal_ready), 0);
      check("R1 result after reset", int'(cal_result), 0);
      check("R1 overflow after reset", int'(cal_overflow), 0);
   endtask

   task automatic t_cycle_default();
      int n;
      wait_ready(2000, n);
      check("R1 cycling from reset ready", int'(cal_ready), 1);
      check("R1 R6 default window result", int'(cal_result), 32);
      check("R7 no overflow", int'(cal_overflow), 0);
   endtask

   task automatic t_cycle_update();
      write_cfg(0, 2, 1'b0, 1'b1);
      repeat (200) @(negedge clk);
      check("R6 new window length", int'(cal_result), 16);
      per[0] = 10;
      repeat (200) @(negedge clk);
      check("R6 refreshed after period change", int'(cal_result), 20);
   endtask

   task automatic t_idle();
      write_cfg(0, 2, 1'b0, 1'b0);
      per[0] = 8;
      repeat (300) @(negedge clk);
      check("R8 idle keeps result", int'(cal_result), 20);
      check("R8 idle keeps ready", int'(cal_ready), 1);
   endtask

   task automatic t_sources();
      oneshot(0, 3, "R2 source 0", 24);
      oneshot(1, 4, "R2 source 1", 48);
      oneshot(2, 5, "R2 source 2", 30);
      oneshot(3, 2, "R2 reserved code uses source 0", 16);
   endtask

   task automatic t_level();
      write_cfg(1, 7, 1'b1, 1'b0);
      repeat (200) @(negedge clk);
      check("R3 level start keeps ready", int'(cal_ready), 1);
      check("R3 level start keeps result", int'(cal_result), 16);
   endtask

   task automatic t_zero();
      int n;
      write_cfg(0, 0, 1'b0, 1'b0);
      write_cfg(0, 0, 1'b1, 1'b0);
      @(negedge clk);
      check("R5 ready dropped", int'(cal_ready), 0);
      wait_ready(100, n);
      check("R5 ready at next slow edge", int'(cal_ready), 1);
      check("R5 latency within one period", int'(n <= 12), 1);
      check("R5 zero result", int'(cal_result), 0);
   endtask

   task automatic t_overflow();
      oneshot(0, 200, "R7 saturated result", 1023);
      check("R7 overflow raised", int'(cal_overflow), 1);
      oneshot(0, 3, "R7 normal result after overflow", 24);
      check("R7 overflow cleared", int'(cal_overflow), 0);
   endtask

   task automatic t_abort();
      write_cfg(0, 100, 1'b0, 1'b0);
      write_cfg(0, 100, 1'b1, 1'b0);
      repeat (50) @(negedge clk);
      write_cfg(0, 100, 1'b0, 1'b0);
      repeat (1200) @(negedge clk);
      check("R8 abort leaves ready low", int'(cal_ready), 0);
      check("R8 abort keeps result", int'(cal_result), 24);
   endtask

   initial begin
      per[0] = 8; per[1] = 12; per[2] = 6;
      ph[0] = 0;  ph[1] = 0;   ph[2] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cycle_default();
      t_cycle_update();
      t_idle();
      t_sources();
      t_level();
      t_zero();
      t_overflow();
      t_abort();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1500000;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule